// File: doc/BRIEF.md
# Polled and Interrupt-Driven Peripheral Register Block

This block sits on a simple processor read/write bus and presents a small peripheral as six 16-bit registers at fixed word addresses. Three registers hold data and three hold control flags. One channel carries input. The device delivers a byte, the block stores it and raises a ready flag. Software then reads the byte and writes a cleanup value to re-arm the channel. The other channel carries output. Software loads a data word, sets a start flag and waits for a completion flag. It then clears the control register to close the transfer.

The device side uses plain strobes. An input strobe carries a byte. The output side offers a byte with a valid signal and takes a ready signal back. A registered interrupt request is raised while input data is waiting, so software can be driven by interrupts instead of polling. Only the cleanup write takes the request down. The third data and control registers are plain read/write storage for software. Bus reads are combinational from the address, and they have no side effects.

Top module: `mmio_dev_regs`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `out_valid` is low.
- R2: The registers sit at RX data 0xFF00, TX data 0xFF02, spare data 0xFF04, RX control 0xFF06, TX control 0xFF08 and spare control 0xFF0A. Both spare registers store any written 16-bit value. Any other address reads zero and ignores writes.
- R3: An `in_valid` cycle while RX control bit 0 is clear stores `in_data`, zero-extended, into RX data. It also sets RX control bit 0 from the next cycle on.
- R4: An `in_valid` cycle while RX control bit 0 is set leaves RX data unchanged and sets RX control bit 2, the overrun bit.
- R5: A write to RX control with bit 0 of the written value at 0 clears RX control bits 0 and 2. A write with bit 0 at 1 changes neither bit. If the clearing write and `in_valid` fall in the same cycle, the new byte is captured, bit 0 reads 1 and bit 2 reads 0.
- R6: `irq` is RX control bit 0 delayed by one register. It rises one cycle after the bit is set and falls one cycle after the bit is cleared.
- R7: A write to TX control with bit 0 at 1, made while no transfer is in progress, sets TX control bit 0 and clears bit 1. From the next cycle, `out_valid` is high and `out_data` carries the low byte of TX data.
- R8: A cycle with both `out_valid` and `out_ready` high ends the transfer. `out_valid` falls on the next cycle and TX control bit 1 is set.
- R9: While a transfer is in progress (TX control bit 0 set and bit 1 clear), writes to TX data and to TX control are ignored.
- R10: A write to TX control made while no transfer is in progress loads bit 0 from the written value and clears bit 1. Writing zero therefore closes a completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| in_valid | input | 1 | Device offers an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output transfer in progress, byte offered |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Device accepts the output byte |
| irq | output | 1 | Interrupt request while input data waits |

## Verification
On every cycle, the assertions check several timing rules. They check the one-cycle delay of the interrupt behind the cleanup write. They check that a start write leads to `out_valid`, and that a handshake leads to the done flag. They check that a pending overrun is recorded, and that the output byte and the stored input byte stay stable while they are locked. The same-cycle race between cleanup and a new byte is left to the bench. So are the values read at each address, the spare-register storage, and the reads from unmapped addresses. The bench's scenarios also cover the ignored writes during a transfer, and the long mixes of input, output and bus traffic that only a reference model can follow.

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs #(
  parameter int          AW   = 16,
  parameter int          DW   = 16,
  parameter int          BW   = 8,
  parameter logic [15:0] BASE = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  input  logic          out_ready,
  output logic          irq
);

  localparam logic [AW-1:0] A_RXD = AW'(BASE);
  localparam logic [AW-1:0] A_TXD = AW'(BASE + 16'd2);
  localparam logic [AW-1:0] A_SPD = AW'(BASE + 16'd4);
  localparam logic [AW-1:0] A_RXC = AW'(BASE + 16'd6);
  localparam logic [AW-1:0] A_TXC = AW'(BASE + 16'd8);
  localparam logic [AW-1:0] A_SPC = AW'(BASE + 16'd10);

  logic [DW-1:0] rx_q, tx_q, sp_d_q, sp_c_q;
  logic          rx_full, rx_ovr, tx_go, tx_done;

  wire wr_rxc = bus_wr && (bus_addr == A_RXC);
  wire wr_txc = bus_wr && (bus_addr == A_TXC);
  wire wr_txd = bus_wr && (bus_addr == A_TXD);
  wire rx_clr = wr_rxc && !bus_wdata[0];
  wire tx_busy = tx_go && !tx_done;
  wire tx_hs  = out_valid && out_ready;

  assign out_valid = tx_busy;
  assign out_data  = tx_q[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= rx_full;
      if (in_valid && (!rx_full || rx_clr)) begin
        rx_q    <= DW'(in_data);
        rx_full <= 1'b1;
      end else if (rx_clr) begin
        rx_full <= 1'b0;
      end
      if (rx_clr)
        rx_ovr <= 1'b0;
      else if (in_valid && rx_full)
        rx_ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      tx_go   <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      if (wr_txd && !tx_busy)
        tx_q <= bus_wdata;
      if (wr_txc && !tx_busy) begin
        tx_go   <= bus_wdata[0];
        tx_done <= 1'b0;
      end else if (tx_hs) begin
        tx_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_d_q <= '0;
      sp_c_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_SPD) sp_d_q <= bus_wdata;
      if (bus_addr == A_SPC) sp_c_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RXD: bus_rdata = rx_q;
      A_TXD: bus_rdata = tx_q;
      A_SPD: bus_rdata = sp_d_q;
      A_RXC: bus_rdata = DW'({rx_ovr, 1'b0, rx_full});
      A_TXC: bus_rdata = DW'({tx_done, tx_go});
      A_SPC: bus_rdata = sp_c_q;
      default: bus_rdata = '0;
    endcase
  end

  // R6: cleanup without a new byte drops irq two edges later
  a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !in_valid) |=> ##1 !irq);

  // R4: a byte offered while full records an overrun
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_full && !rx_clr) |=> rx_ovr);

  // R4: stored byte is held while full and not cleaned up
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_clr) |=> $stable(rx_q));

  // R7: accepted start write offers the byte next cycle
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txc && bus_wdata[0] && !out_valid) |=> out_valid);

  // R8: handshake ends the transfer and flags completion
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && tx_done));

  // R9: output byte stays put during a transfer
  a_r9_tx_lock: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(out_data));

endmodule

// File: tb/mmio_dev_regs_bench.sv
module mmio_dev_regs_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        irq;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_NS/2) clk = ~clk;

  mmio_dev_regs u_mmio_dev_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .irq(irq)
  );

  // reference state
  logic [15:0] m_rx, m_tx, m_spd, m_spc;
  logic        m_full, m_ovr, m_irq, m_go, m_done;

  function automatic logic m_busy();
    return m_go && !m_done;
  endfunction

  function automatic logic [15:0] m_read(input logic [15:0] a);
    case (a)
      16'hFF00: return m_rx;
      16'hFF02: return m_tx;
      16'hFF04: return m_spd;
      16'hFF06: return {13'd0, m_ovr, 1'b0, m_full};
      16'hFF08: return {14'd0, m_done, m_go};
      16'hFF0A: return m_spc;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'hFF00: return "R3";
      16'hFF02: return "R9";
      16'hFF06: return "R5";
      16'hFF08: return "R10";
      default:  return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = '0; m_tx = '0; m_spd = '0; m_spc = '0;
      m_full = 0; m_ovr = 0; m_irq = 0; m_go = 0; m_done = 0;
    end else begin
      logic clr, busy, hs;
      clr  = bus_wr && bus_addr == 16'hFF06 && !bus_wdata[0];
      busy = m_busy();
      hs   = busy && out_ready;
      m_irq = m_full;
      if (clr) m_ovr = 0; else if (in_valid && m_full) m_ovr = 1;
      if (in_valid && (!m_full || clr)) begin m_rx = {8'd0, in_data}; m_full = 1; end
      else if (clr) m_full = 0;
      if (bus_wr && bus_addr == 16'hFF02 && !busy) m_tx = bus_wdata;
      if (bus_wr && bus_addr == 16'hFF08 && !busy) begin m_go = bus_wdata[0]; m_done = 0; end
      else if (hs) m_done = 1;
      if (bus_wr && bus_addr == 16'hFF04) m_spd = bus_wdata;
      if (bus_wr && bus_addr == 16'hFF0A) m_spc = bus_wdata;
    end
  end

  task automatic chk(input string rq, input string what, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  // drive one cycle at the falling edge, then check outputs in the low phase
  task automatic step(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                      input logic iv, input logic [7:0] id, input logic ordy,
                      input string rq_override);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    in_valid = iv; in_data = id; out_ready = ordy;
    #1;
    chk(rq_override == "" ? tag_of(a) : rq_override, "rdata", bus_rdata, m_read(a));
    chk("R6", "irq", {15'd0, irq}, {15'd0, m_irq});
    chk("R7", "out_valid", {15'd0, out_valid}, {15'd0, m_busy()});
    if (m_busy()) chk("R7", "out_data", {8'd0, out_data}, {8'd0, m_tx[7:0]});
  endtask

  task automatic idle_read(input logic [15:0] a, input string rq);
    step(1'b0, a, 16'h0, 1'b0, 8'h0, 1'b0, rq);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] amap [8];
    void'($urandom(32'h5EED_1234));
    amap = '{16'hFF00, 16'hFF02, 16'hFF04, 16'hFF06, 16'hFF08, 16'hFF0A, 16'hFF01, 16'h0000};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 6; i++) idle_read(amap[i], "R1");
    // R2 spare storage and unmapped
    step(1'b1, 16'hFF04, 16'hA5C3, 0, 0, 0, "R2");
    step(1'b1, 16'hFF0C, 16'hFFFF, 0, 0, 0, "R2");
    idle_read(16'hFF04, "R2");
    idle_read(16'hFF0C, "R2");
    idle_read(16'hFF03, "R2");
    // R3 capture, R6 irq, R4 overrun
    step(1'b0, 16'hFF06, 0, 1, 8'h3C, 0, "R3");
    idle_read(16'hFF00, "R3");
    step(1'b0, 16'hFF06, 0, 1, 8'h77, 0, "R4");
    idle_read(16'hFF06, "R4");
    idle_read(16'hFF00, "R4");
    // R5 write with bit0 set does nothing, then cleanup
    step(1'b1, 16'hFF06, 16'h0001, 0, 0, 0, "R5");
    idle_read(16'hFF06, "R5");
    step(1'b1, 16'hFF06, 16'h0000, 0, 0, 0, "R5");
    idle_read(16'hFF06, "R5");
    idle_read(16'hFF06, "R6");
    // R5 same-cycle race
    step(1'b0, 16'hFF00, 0, 1, 8'h11, 0, "R3");
    step(1'b1, 16'hFF06, 16'h0000, 1, 8'h22, 0, "R5");
    idle_read(16'hFF06, "R5");
    idle_read(16'hFF00, "R5");
    step(1'b1, 16'hFF06, 16'h0000, 0, 0, 0, "R5");
    // R7 start, R9 lock, R8 done, R10 cleanup
    step(1'b1, 16'hFF02, 16'h12AB, 0, 0, 0, "R7");
    step(1'b1, 16'hFF08, 16'h0001, 0, 0, 0, "R7");
    step(1'b1, 16'hFF02, 16'h0055, 0, 0, 0, "R9");
    step(1'b1, 16'hFF08, 16'h0000, 0, 0, 0, "R9");
    idle_read(16'hFF02, "R9");
    idle_read(16'hFF08, "R9");
    step(1'b0, 16'hFF08, 0, 0, 0, 1, "R8");
    idle_read(16'hFF08, "R8");
    step(1'b1, 16'hFF08, 16'h0000, 0, 0, 0, "R10");
    idle_read(16'hFF08, "R10");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a, wd;
      a  = amap[$urandom_range(0, 7)];
      wd = 16'($urandom);
      if ($urandom_range(0, 1) == 0) wd[0] = 1'b0;
      step($urandom_range(0, 3) == 0, a, wd, $urandom_range(0, 9) < 3,
           8'($urandom), $urandom_range(0, 9) < 4, "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule